// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a four-wire serial control link. It has an active-low chip select, a control clock, a data input and a data output. Behind the link sits a small bank of 8-bit configuration registers. A host sends commands one byte at a time, most significant bit first. Each byte takes eight control-clock pulses while chip select is held low. The first byte of a command is a command byte. It carries a power bit, a read flag, a data-follows flag and a register index. A write command is followed by one data byte, either in the same chip-select window or after chip select has been raised and lowered once. A read command arms a readback, and the register contents are shifted out during the next chip-select-low window.

The control-link inputs are asynchronous to the block clock. They pass through a synchronizer, and edges are detected in the block clock domain, so the control clock must be several block-clock periods slower. The output has a separate enable for the pad driver. The enable is deasserted while chip select is high, which lets several devices share one return line. The power bit of every command byte drives a power-down output directly, and the register bank is presented as a flat bus to the logic it configures.

Top module: `scp_regport`

## Requirements
- R1: After reset, `pwr_down` is 1, `sdo_oe` is 0, and register i holds `INIT_BASE + i` (default 8'hA0 + i).
- R2: A byte is assembled from exactly eight rising control-clock edges with chip select low, MSB first. Command byte fields are: bit 7 power, bit 6 read flag (1 = read), bit 5 data-follows flag, bits 2..0 register index. Bits 4..3 are ignored.
- R3: Every completed command byte copies its bit 7 to `pwr_down` (0 = active, 1 = power-down). A command with read flag 0 and data-follows flag 0 stands alone and changes no register.
- R4: A write command (read 0, data-follows 1) followed by a data byte in the same chip-select window loads that byte into the indexed register.
- R5: The data byte of a write command may instead arrive in a later chip-select-low window, after chip select has gone high in between, with the same result.
- R6: If chip select rises before the eighth rising edge, the partial byte is discarded and the bit counter restarts at zero. A following complete byte decodes normally.
- R7: After a read command, the next chip-select-low window shifts out the indexed register MSB first. Bit 7 is on `sdo` from the start of the window, and each falling control-clock edge advances to the next bit.
- R8: `sdo_oe` is 0 while chip select is high and 1 while it is low.
- R9: Registers change only on a completed write data byte. Read and power-only commands leave every register unchanged.
- R10: Bits shifted in during a readback window are ignored. They change neither the registers nor `pwr_down`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Control clock |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| pwr_down | output | 1 | 1 = power-down, 0 = active |
| cfg_regs | output | NREG*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
Register 3 is written with all 256 data values. This tells apart a stuck, swapped or wrongly ordered bit in the data path from a correct MSB-first assembly. All eight indices are written, alternating between the same-window form and the form with a chip-select pulse between the bytes, and all eight are then read back. This separates index decoding, the cross-window pending state and the falling-edge output shifter. Further tests cover aborted partial bytes, power-only commands with both polarities, and a readback window with a command-like pattern on the input. These show whether a partial shift leaks into the next byte and whether the read window is really isolated from decoding.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int BYTE_W  = 8;
    localparam int PWR_POS = 7;
    localparam int RD_POS  = 6;
    localparam int DF_POS  = 5;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_DATA  = 2'd1,
        ST_ARMED = 2'd2,
        ST_READ  = 2'd3
    } port_st_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int           STAGES  = 2,
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/scp_rx.sv
module scp_rx
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              sclk_fall,
    output logic              cs_fall,
    output logic              cs_rise
);
    typedef struct packed {
        logic              sclk_prev;
        logic              cs_prev;
        logic [2:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              vld;
        logic [BYTE_W-1:0] data;
    } rx_t;

    rx_t rx_d, rx_q;
    logic sclk_rise;

    always_comb begin
        sclk_rise = sclk_s & ~rx_q.sclk_prev & ~cs_n_s;
        sclk_fall = ~sclk_s & rx_q.sclk_prev & ~cs_n_s;
        cs_fall   = rx_q.cs_prev & ~cs_n_s;
        cs_rise   = ~rx_q.cs_prev & cs_n_s;

        rx_d           = rx_q;
        rx_d.sclk_prev = sclk_s;
        rx_d.cs_prev   = cs_n_s;
        rx_d.vld       = 1'b0;
        if (cs_n_s) begin
            rx_d.cnt = 3'd0;
        end else if (sclk_rise) begin
            rx_d.sh  = {rx_q.sh[BYTE_W-2:0], sdi_s};
            rx_d.cnt = rx_q.cnt + 3'd1;
            if (rx_q.cnt == 3'd7) begin
                rx_d.vld  = 1'b1;
                rx_d.data = {rx_q.sh[BYTE_W-2:0], sdi_s};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q           <= '0;
            rx_q.cs_prev   <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld  = rx_q.vld;
    assign byte_data = rx_q.data;

    // R6
    partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (rx_q.cnt == 3'd0));

    // R2
    byte_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.vld |-> $past(!cs_n_s));
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank #(
    parameter int           NREG      = 8,
    parameter int           W         = 8,
    parameter logic [W-1:0] INIT_BASE = 8'hA0,
    localparam int          IDX_W     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [W-1:0]      wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [W-1:0]      rd_data,
    output logic [NREG*W-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && (wr_idx == IDX_W'(g))) r_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= INIT_BASE + W'(g);
            else        r_q <= r_d;
        end

        assign regs_flat[g*W +: W] = r_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i)) rd_data = regs_flat[i*W +: W];
    end

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/scp_regport.sv
module scp_regport
    import scp_pkg::*;
#(
    parameter int          NREG        = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  INIT_BASE   = 8'hA0,
    localparam int         IDX_W       = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_oe,
    output logic               pwr_down,
    output logic [NREG*8-1:0]  cfg_regs
);
    logic cs_n_s, sclk_s, sdi_s;
    logic byte_vld, sclk_fall, cs_fall, cs_rise;
    logic [BYTE_W-1:0] byte_data, rd_data;
    logic wr_en;
    logic unused_rsv;

    scp_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .din({cs_n, sclk, sdi}), .dout({cs_n_s, sclk_s, sdi_s})
    );

    scp_rx i_rx (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .sclk_fall(sclk_fall), .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    typedef struct packed {
        port_st_e          st;
        logic [IDX_W-1:0]  idx;
        logic              pwr;
        logic              oe;
        logic [BYTE_W-1:0] osh;
    } port_t;

    port_t p_d, p_q;

    assign unused_rsv = ^byte_data[4:IDX_W];

    always_comb begin
        p_d    = p_q;
        wr_en  = 1'b0;
        p_d.oe = ~cs_n_s;
        unique case (p_q.st)
            ST_CMD: begin
                if (byte_vld) begin
                    p_d.pwr = byte_data[PWR_POS];
                    p_d.idx = byte_data[IDX_W-1:0];
                    if (byte_data[RD_POS])      p_d.st = ST_ARMED;
                    else if (byte_data[DF_POS]) p_d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (byte_vld) begin
                    wr_en  = 1'b1;
                    p_d.st = ST_CMD;
                end
            end
            ST_ARMED: begin
                if (cs_fall) begin
                    p_d.st  = ST_READ;
                    p_d.osh = rd_data;
                end
            end
            ST_READ: begin
                if (cs_rise)        p_d.st  = ST_CMD;
                else if (sclk_fall) p_d.osh = {p_q.osh[BYTE_W-2:0], 1'b0};
            end
            default: p_d.st = ST_CMD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q     <= '0;
            p_q.st  <= ST_CMD;
            p_q.pwr <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    scp_regbank #(.NREG(NREG), .W(BYTE_W), .INIT_BASE(INIT_BASE)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(p_q.idx), .wr_data(byte_data),
        .rd_idx(p_q.idx), .rd_data(rd_data), .regs_flat(cfg_regs)
    );

    assign sdo      = (p_q.st == ST_READ) ? p_q.osh[BYTE_W-1] : 1'b0;
    assign sdo_oe   = p_q.oe;
    assign pwr_down = p_q.pwr;

    // R8
    oe_follows_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !sdo_oe);

    // R3
    pwr_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(pwr_down));

    // R7
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.st == ST_READ && !sclk_fall && !cs_rise) |=> $stable(sdo));

    // R10
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.st == ST_READ) |=> $stable(cfg_regs) && $stable(pwr_down));
endmodule

// File: tb/test_scp_regport.sv
module test_scp_regport;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, pwr_down;
    logic [NREG*8-1:0] cfg_regs;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] exp_reg [NREG];
    logic exp_pwr;

    always #10 clk = ~clk;

    scp_regport #(.NREG(NREG)) i_scp_regport (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .pwr_down(pwr_down), .cfg_regs(cfg_regs)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            wait_n(4);
            sclk = 1'b1;
            wait_n(8);
            sclk = 1'b0;
            wait_n(4);
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        wait_n(8);
    endtask

    task automatic cs_high();
        wait_n(4);
        cs_n = 1'b1;
        wait_n(10);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, cfg_regs[i*8 +: 8], exp_reg[i]);
    endtask

    task automatic write_reg(input int idx, input logic [7:0] v, input bit split);
        cs_low();
        send_bits({exp_pwr, 1'b0, 1'b1, 2'b00, 3'(idx)}, 8);
        if (split) begin
            cs_high();
            cs_low();
        end
        send_bits(v, 8);
        cs_high();
        exp_reg[idx] = v;
    endtask

    task automatic read_reg(input int idx, input logic [7:0] junk, output logic [7:0] got);
        cs_low();
        send_bits({exp_pwr, 1'b1, 1'b0, 2'b00, 3'(idx)}, 8);
        cs_high();
        cs_low();
        chk("R8 oe low window", {63'd0, sdo_oe}, 64'd1);
        got[7] = sdo;
        for (int k = 0; k < 8; k++) begin
            sdi = junk[7-k];
            sclk = 1'b1;
            wait_n(8);
            sclk = 1'b0;
            wait_n(8);
            if (k < 7) got[6-k] = sdo;
        end
        cs_high();
        chk("R8 oe high cs", {63'd0, sdo_oe}, 64'd0);
    endtask

    initial begin
        logic [7:0] got;
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'hA0 + 8'(i);
        exp_pwr = 1'b1;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        // R1 reset state
        chk("R1 pwr_down", {63'd0, pwr_down}, 64'd1);
        chk("R1 sdo_oe", {63'd0, sdo_oe}, 64'd0);
        check_bank("R1 defaults");

        // R3 power-only commands, both polarities
        exp_pwr = 1'b0;
        cs_low(); send_bits(8'h00, 8); cs_high();
        chk("R3 active", {63'd0, pwr_down}, 64'd0);
        exp_pwr = 1'b1;
        cs_low(); send_bits(8'h9F, 8); cs_high();
        chk("R3 power-down", {63'd0, pwr_down}, 64'd1);
        check_bank("R9 power cmd keeps regs");
        exp_pwr = 1'b0;
        cs_low(); send_bits(8'h18, 8); cs_high();
        chk("R3 active reserved bits R2", {63'd0, pwr_down}, 64'd0);

        // R2 exhaustive data values on register 3
        for (int v = 0; v < 256; v++) begin
            write_reg(3, 8'(v), v[0]);
            chk("R2 data sweep", {56'd0, cfg_regs[3*8 +: 8]}, 64'(v));
        end

        // R4 / R5 all indices, alternating forms
        for (int i = 0; i < NREG; i++) begin
            write_reg(i, 8'((i * 37 + 5)) ^ 8'h5A, i[0]);
            check_bank(i[0] ? "R5 split write" : "R4 same-window write");
        end

        // R7 read back every register, junk on sdi is R10
        for (int i = 0; i < NREG; i++) begin
            read_reg(i, 8'h00, got);
            chk("R7 readback", {56'd0, got}, {56'd0, exp_reg[i]});
        end
        check_bank("R9 reads keep regs");

        // R10 command-like pattern during readback window
        read_reg(5, 8'hA5, got);
        chk("R7 readback with junk", {56'd0, got}, {56'd0, exp_reg[5]});
        chk("R10 pwr unchanged", {63'd0, pwr_down}, 64'd0);
        check_bank("R10 regs unchanged");

        // R6 partial byte discarded
        cs_low(); send_bits(8'hFF, 5); cs_high();
        check_bank("R6 partial no effect");
        chk("R6 partial pwr", {63'd0, pwr_down}, 64'd0);
        cs_low(); send_bits(8'hE6, 3); cs_high();
        write_reg(6, 8'h3C, 1'b0);
        check_bank("R6 decode after abort");
        read_reg(6, 8'h00, got);
        chk("R6 readback after abort", {56'd0, got}, 64'h3C);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule